// File: doc/BRIEF.md
# SPI Register Slave with One-Frame Response Delay

This block lets an external SPI master reach a small register file: one writable control register and a set of read-only status registers. Every transaction is a frame framed by an active-low chip select. The first byte is a command holding a write flag and an address, and the second byte is write data, or a filler byte for a read. The serial clock, data and chip select are first brought into the system clock domain through flop synchronizers. All shifting and decoding then runs on the system clock.

The outgoing shift register is reloaded only when a byte ends, at the falling serial-clock edge after the eighth bit. The byte a master receives while it sends a command is therefore the answer to its previous command. During the second byte the master receives the present contents of the register it has just addressed. A write lands in the control register only when chip select is released. The status registers copy their inputs only while chip select is high, so they stay frozen for the whole of a frame.

Top module: `spi_regslave`

## Requirements
- R1: After reset the control output is 0x00 and the serial output is low. The first byte returned in the first frame after reset is the marker 0xA5.
- R2: The serial interface uses mode 0 with the most significant bit first. The master samples the output on rising clock edges, and the output changes on falling edges. The output is driven low while chip select is high.
- R3: The first byte returned in a frame is the value of the register addressed by the previous frame's command, as it stood at the end of that frame and before any write from it was committed.
- R4: The second byte returned in a frame is the current contents of the register addressed by the same frame's command byte. For a write, this is the old value.
- R5: Command bit 7 set means write, and bits 6:0 hold the address. The control register sits at address 2. A write to it changes the control output only after chip select rises, never while the frame is open.
- R6: Status register k (address 4 + k, input slice status_in[8k+7:8k]) follows its input only while chip select is high. It holds its value while chip select is low.
- R7: Writes to status addresses and to unused addresses have no effect. Unused addresses read as 0x00.
- R8: A frame ends with no write if its bit count is not a multiple of eight, or if it holds fewer than two complete bytes.
- R9: A read of the control register in the frame that follows a write to it returns the old value in the first byte and the new value in the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| status_in | input | 8*NUM_STAT | Internal status values, one byte per status register |
| ctrl_out | output | 8 | Committed control register value |

## Verification
A serial edge reaches the block's edge detectors after two synchronizer flops and one history flop. A bit is captured, or the output shifts, one system cycle after that. A committed write shows on the control output one cycle after the chip-select rise is detected, so about four cycles after the pin moves. The bench holds each serial clock phase and each chip-select setup for eight system cycles. It samples the serial output just before it raises the clock, and it reads the control output twice: once before it releases chip select, to show the write is not yet visible, and again sixteen cycles after the release.

// File: rtl/spi_regslave_pkg.sv
// Package: shared widths and types for the SPI register slave.
// Assumes byte-wide frames; the command byte splits into a write flag and a 7-bit address.
package spi_regslave_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    // Command byte layout: bit 7 write flag, bits 6:0 register address
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // Number of complete bytes seen in the current frame, saturating
    typedef enum logic [1:0] {
        BYTES_NONE = 2'd0,
        BYTES_CMD  = 2'd1,
        BYTES_DATA = 2'd2
    } byte_cnt_e;

endpackage

// File: rtl/spi_sync.sv
// Module: brings the serial clock, data and chip select into the system clock domain
// through a flop chain each, then derives single-cycle edge pulses.
// Assumes the serial clock is several times slower than the system clock.
module spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_active,
    output logic mosi_s
);

    localparam int NSIG = 3;
    // Idle levels per signal, ordered {cs_n, mosi, sclk}
    localparam logic [NSIG-1:0] IDLE = 3'b100;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] sync_v;
    logic            sclk_d;
    logic            csn_d;

    assign raw = {cs_n, mosi, sclk};

    for (genvar g = 0; g < NSIG; g++) begin : g_chain
        logic [STAGES-1:0] ff;
        // Shift one input through its synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) ff <= {STAGES{IDLE[g]}};
            else        ff <= {ff[STAGES-2:0], raw[g]};
        end
        assign sync_v[g] = ff[STAGES-1];
    end

    // Keep last synchronized clock and select levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sync_v[0];
            csn_d  <= sync_v[2];
        end
    end

    assign sclk_rise = sync_v[0] & ~sclk_d;
    assign sclk_fall = ~sync_v[0] & sclk_d;
    assign cs_fall   = ~sync_v[2] & csn_d;
    assign cs_rise   = sync_v[2] & ~csn_d;
    assign cs_active = ~sync_v[2];
    assign mosi_s    = sync_v[1];

endmodule

// File: rtl/spi_shifter.sv
// Module: serial framing. It collects input bits into the command and data bytes,
// reloads the output shift register at each byte end, and flags a write commit when a
// well-formed frame closes. Assumes single-cycle edge pulses from spi_sync.
module spi_shifter
    import spi_regslave_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NOT_VALID = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cs_active,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output cmd_t              cmd,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit,
    output logic              miso
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] in_sr;
    logic [CNT_W-1:0]  bit_cnt;
    byte_cnt_e         byte_cnt;
    cmd_t              cmd_q;
    logic [BYTE_W-1:0] data_q;
    logic              load_pend;
    logic [BYTE_W-1:0] out_sr;
    logic [BYTE_W-1:0] resp_q;
    logic              commit_q;
    logic [BYTE_W-1:0] full_byte;

    assign full_byte = {in_sr, mosi_s};

    // Capture input bits on rising edges and store complete bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr     <= '0;
            bit_cnt   <= '0;
            byte_cnt  <= BYTES_NONE;
            cmd_q     <= '0;
            data_q    <= '0;
            load_pend <= 1'b0;
        end else if (cs_fall) begin
            bit_cnt   <= '0;
            byte_cnt  <= BYTES_NONE;
            load_pend <= 1'b0;
        end else if (cs_active && sclk_rise) begin
            in_sr   <= full_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                load_pend <= 1'b1;
                if (byte_cnt == BYTES_NONE) begin
                    cmd_q    <= full_byte;
                    byte_cnt <= BYTES_CMD;
                end else begin
                    data_q   <= full_byte;
                    byte_cnt <= BYTES_DATA;
                end
            end
        end else if (cs_active && sclk_fall) begin
            load_pend <= 1'b0;
        end
    end

    // Drive the output register: replay the held answer at frame start, reload at byte end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr <= NOT_VALID;
            resp_q <= NOT_VALID;
        end else if (cs_fall) begin
            out_sr <= resp_q;
        end else if (cs_active && sclk_fall) begin
            if (load_pend) begin
                out_sr <= rd_data;
                resp_q <= rd_data;
            end else begin
                out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // Flag a write when the frame closes on a byte boundary with a data byte present
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= cs_rise && (bit_cnt == '0) &&
                                (byte_cnt == BYTES_DATA) && cmd_q.wr;
    end

    assign cmd     = cmd_q;
    assign wr_data = data_q;
    assign commit  = commit_q;
    assign miso    = cs_active ? out_sr[BYTE_W-1] : 1'b0;

    AST_RESP_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_q) |-> $past(sclk_fall)); // R3
    AST_RESP_RESET_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> resp_q == NOT_VALID); // R1
    AST_COMMIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> !cs_active); // R5
    AST_CMD_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> $stable(cmd_q)); // R3

endmodule

// File: rtl/spi_regfile.sv
// Module: the register file. It holds one writable control register and NUM_STAT status
// snapshots, and serves reads through a combinational mux. Assumes status_in is
// synchronous to clk and that commit is a single-cycle pulse.
module spi_regfile
    import spi_regslave_pkg::*;
#(
    parameter int                CTRL_ADDR = 2,
    parameter int                STAT_BASE = 4,
    parameter int                NUM_STAT  = 2,
    parameter logic [BYTE_W-1:0] CTRL_RST  = 8'h00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snap_en,
    input  logic [NUM_STAT*BYTE_W-1:0] status_in,
    input  logic                       commit,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [BYTE_W-1:0]          ctrl_out
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [BYTE_W-1:0]                ctrl_q;
    logic [NUM_STAT-1:0][BYTE_W-1:0]  stat_q;

    // Commit a write to the control register when the frame closes
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= CTRL_RST;
        else if (commit && (addr == CTRL_A)) ctrl_q <= wr_data;
    end

    // Refresh the status snapshots only while chip select is inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (snap_en) begin
            for (int k = 0; k < NUM_STAT; k++)
                stat_q[k] <= status_in[k*BYTE_W +: BYTE_W];
        end
    end

    // Select the addressed register; unused addresses give zero
    always_comb begin
        rd_data = '0;
        if (addr == CTRL_A) rd_data = ctrl_q;
        for (int k = 0; k < NUM_STAT; k++)
            if (addr == ADDR_W'(STAT_BASE + k)) rd_data = stat_q[k];
    end

    assign ctrl_out = ctrl_q;

    AST_CTRL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(commit)); // R5
    AST_STAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(stat_q)); // R6
    AST_CTRL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ctrl_q == CTRL_RST); // R1

endmodule

// File: rtl/spi_regslave.sv
// Module: top of the SPI register slave. It joins the synchronizers, the serial framer
// and the register file. Assumes mode 0 timing, with each serial clock phase lasting
// at least four system clock cycles and chip select set up just as long before the first edge.
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                CTRL_ADDR   = 2,
    parameter int                STAT_BASE   = 4,
    parameter int                NUM_STAT    = 2,
    parameter logic [BYTE_W-1:0] NOT_VALID   = 8'hA5,
    parameter logic [BYTE_W-1:0] CTRL_RST    = 8'h00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [NUM_STAT*BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0]          ctrl_out
);

    logic              sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active, mosi_s;
    cmd_t              cmd;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              commit;

    spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_shifter #(.NOT_VALID(NOT_VALID)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_active (cs_active),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .cmd       (cmd),
        .wr_data   (wr_data),
        .commit    (commit),
        .miso      (spi_miso)
    );

    spi_regfile #(
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_BASE (STAT_BASE),
        .NUM_STAT  (NUM_STAT),
        .CTRL_RST  (CTRL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_en   (!cs_active),
        .status_in (status_in),
        .commit    (commit),
        .addr      (cmd.addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ctrl_out  (ctrl_out)
    );

endmodule

// File: tb/spi_regslave_bench.sv
// Bench: directed scenarios acting as an SPI master; each task checks its own results.
module spi_regslave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] status_in = 16'h2211;
    logic [7:0]  ctrl_out;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regslave u_spi_regslave (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .status_in (status_in),
        .ctrl_out  (ctrl_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(4);
    endtask

    // Shift n bits MSB first; the output is sampled just before each rising edge
    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            wait_cycles(HALF);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            wait_cycles(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_open();
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_cycles(HALF);
    endtask

    task automatic frame_close();
        wait_cycles(HALF);
        spi_cs_n = 1'b1;
        wait_cycles(2*HALF);
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] d,
                         output logic [7:0] b0, output logic [7:0] b1);
        frame_open();
        xfer_bits(c, 8, b0);
        xfer_bits(d, 8, b1);
        frame_close();
    endtask

    task automatic t_reset_state();
        logic [7:0] b0, b1;
        check("R1 ctrl after reset", ctrl_out, 8'h00);
        check("R2 miso idle", {7'd0, spi_miso}, 8'h00);
        frame(8'h02, 8'h00, b0, b1);
        check("R1 first byte marker", b0, 8'hA5);
        check("R4 R2 read ctrl second byte", b1, 8'h00);
    endtask

    task automatic t_write_then_read();
        logic [7:0] b0, b1;
        frame_open();
        xfer_bits(8'h82, 8, b0);
        xfer_bits(8'h3C, 8, b1);
        check("R3 previous answer", b0, 8'h00);
        check("R4 old data during write", b1, 8'h00);
        check("R5 no update before release", ctrl_out, 8'h00);
        frame_close();
        check("R5 update after release", ctrl_out, 8'h3C);
        frame(8'h02, 8'h00, b0, b1);
        check("R9 old data again", b0, 8'h00);
        check("R9 new data second byte", b1, 8'h3C);
    endtask

    task automatic t_status_snapshot();
        logic [7:0] b0, b1;
        frame_open();
        status_in[7:0] = 8'h77;
        xfer_bits(8'h04, 8, b0);
        xfer_bits(8'h00, 8, b1);
        frame_close();
        check("R3 answer of ctrl read", b0, 8'h3C);
        check("R6 snapshot frozen in frame", b1, 8'h11);
        frame(8'h05, 8'h00, b0, b1);
        check("R6 R3 deferred status 4", b0, 8'h11);
        check("R6 status 5", b1, 8'h22);
        frame(8'h04, 8'h00, b0, b1);
        check("R3 deferred status 5", b0, 8'h22);
        check("R6 refreshed while idle", b1, 8'h77);
    endtask

    task automatic t_ignored_writes();
        logic [7:0] b0, b1;
        frame(8'h84, 8'h00, b0, b1);
        frame(8'h04, 8'h00, b0, b1);
        check("R7 status write ignored", b1, 8'h77);
        frame(8'h87, 8'h55, b0, b1);
        frame(8'h07, 8'h00, b0, b1);
        check("R7 unused address reads zero", b1, 8'h00);
        check("R7 ctrl untouched", ctrl_out, 8'h3C);
    endtask

    task automatic t_bad_frames();
        logic [7:0] b0, b1, bx;
        frame_open();
        xfer_bits(8'h82, 8, b0);
        xfer_bits(8'hAA, 4, b1);
        frame_close();
        check("R3 answer of unused read", b0, 8'h00);
        check("R8 twelve-bit frame", ctrl_out, 8'h3C);
        frame_open();
        xfer_bits(8'h82, 8, b0);
        frame_close();
        check("R8 command-only frame", ctrl_out, 8'h3C);
        frame_open();
        xfer_bits(8'h82, 8, b0);
        xfer_bits(8'hAA, 8, b1);
        xfer_bits(8'hFF, 4, bx);
        frame_close();
        check("R8 twenty-bit frame", ctrl_out, 8'h3C);
        check("R2 miso low when deselected", {7'd0, spi_miso}, 8'h00);
    endtask

    task automatic t_midrun_reset();
        logic [7:0] b0, b1;
        do_reset();
        check("R1 ctrl cleared", ctrl_out, 8'h00);
        frame(8'h02, 8'h00, b0, b1);
        check("R1 marker after reset", b0, 8'hA5);
        check("R1 ctrl reads reset value", b1, 8'h00);
    endtask

    initial begin
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(4);
        t_reset_state();
        t_write_then_read();
        t_status_snapshot();
        t_ignored_writes();
        t_bad_frames();
        t_midrun_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule